// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block decides where a small 8-bit processor goes next. It takes one decoded flow-control operation at a time, together with the two operand bytes, the HL register pair and the four flag bits. It then loads its program counter with the target, the HL value or the next sequential address. Jumps, conditional jumps and register-indirect jumps finish in one cycle. Calls and restarts push a 16-bit return address onto a downward-growing stack. Returns pop a 16-bit address back into the program counter. Both stack operations go through a byte-wide port to a synchronous RAM, which makes one access per cycle and returns read data one cycle after the read.

Operations enter on a valid/ready pair. The source holds `op_valid` and every operation field steady until a clock edge at which `op_ready` is high. The block latches what it needs at that edge, and the source may change the fields after it. While a stack operation is in progress, `op_ready` is low and nothing is accepted. The block pulses `done` for one cycle when an operation ends. In that cycle `pc` and `sp` show the new values and `op_ready` is high again. Operations can therefore be issued back to back.

The operation kind `op_kind` is coded as follows: 0 is a direct jump, 1 is a jump through HL, 2 is a call, 3 is a return and 4 is a restart. Codes 5, 6 and 7 are plain one-byte instructions.

Top module: `flow_seq`

## Requirements
- R1: When `op_cond_en` is 1, a jump, call or return takes place only if the condition on `op_cond` holds. The codes are: 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 parity flag clear (odd), 101 parity flag set (even), 110 sign clear (plus), 111 sign set (minus). When `op_cond_en` is 0, the operation always takes place.
- R2: A jump that takes place loads `pc` with `{op_hi, op_lo}`. A jump that does not take place loads `pc` with `pc+3`, wrapping modulo 2^16. `done` is high in the cycle after the accepting edge, and there is no memory access.
- R3: A jump through HL loads `pc` with `hl` in one cycle, whatever the condition fields and flags are.
- R4: A call that takes place writes `pc+3` to memory. The high byte goes to address `sp-1` in the first cycle after acceptance and the low byte goes to `sp-2` in the second cycle. Then `sp` drops by 2, `pc` becomes `{op_hi, op_lo}` and `done` is high in the third cycle after acceptance. A call that does not take place only loads `pc+3`, in one cycle, with no memory access.
- R5: A return that takes place reads address `sp` in the first cycle after acceptance and `sp+1` in the second. `pc` becomes {byte read at sp+1, byte read at sp}, `sp` rises by 2 and `done` is high in the fourth cycle after acceptance. A return that does not take place loads `pc+1` in one cycle with no memory access.
- R6: A restart numbered `op_vec` (0 to 7) ignores the condition. It pushes `pc+1` in the same way as a call and loads `pc` with `op_vec*8`.
- R7: From the accepting edge of a call, restart or return that takes place until its `done` cycle, `op_ready` is low and `done` is low. Any operation offered in that time is not accepted and has no effect on `pc`.
- R8: Kinds 5, 6 and 7 load `pc+1` in one cycle, with no memory access and no change to `sp`.
- R9: After reset, `pc` equals `PC_RESET` and `sp` equals `SP_RESET`. `op_ready` is 1, and `done` and `mem_en` are 0.
- R10: While no operation is accepted and no stack operation is finishing, `pc` and `sp` hold and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The sequencer can accept an operation |
| op_kind | input | 3 | Operation kind: 0 jump, 1 HL jump, 2 call, 3 return, 4 restart, 5 to 7 sequential |
| op_cond_en | input | 1 | Apply the condition test |
| op_cond | input | 3 | Condition code, see R1 |
| op_vec | input | 3 | Restart number |
| op_lo | input | 8 | Low target byte (instruction byte 2) |
| op_hi | input | 8 | High target byte (instruction byte 3) |
| hl | input | 16 | HL register pair |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag, 1 means even |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| done | output | 1 | One-cycle pulse when an operation ends |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The bench builds the block with `PC_RESET` = 0x0100 and `SP_RESET` = 0x1000. With that stack start, the first push writes 0x0FFF and 0x0FFE, so the borrow out of the low byte of `sp` is exercised on the first call. A jump to 0xFFFE followed by a jump that does not take place checks the wrap of `pc+3` to 0x0001. The random stream nests calls and returns, so the pops return bytes that earlier pushes wrote.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int VEC_W     = 3;
  localparam int VEC_SHIFT = 3;
  localparam int KIND_W    = 3;

  localparam logic [KIND_W-1:0] K_JMP  = 3'd0;
  localparam logic [KIND_W-1:0] K_JHL  = 3'd1;
  localparam logic [KIND_W-1:0] K_CALL = 3'd2;
  localparam logic [KIND_W-1:0] K_RET  = 3'd3;
  localparam logic [KIND_W-1:0] K_RST  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_FIN
  } stk_state_e;
endpackage

// File: rtl/flow_cond.sv
module flow_cond (
  input  logic [2:0] cond,
  input  logic       flag_z,
  input  logic       flag_c,
  input  logic       flag_s,
  input  logic       flag_p,
  output logic       pass
);
  logic sel;

  // cond[2:1] picks the flag, cond[0] is the level that passes
  always_comb begin
    unique case (cond[2:1])
      2'b00:   sel = flag_z;
      2'b01:   sel = flag_c;
      2'b10:   sel = flag_p;
      default: sel = flag_s;
    endcase
    pass = (sel == cond[0]);
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack
  import flow_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [ADDR_W-1:0] push_word,
  output logic              idle,
  output logic              fin,
  output logic [ADDR_W-1:0] pop_word,
  output logic [ADDR_W-1:0] sp,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  stk_state_e        state;
  logic [ADDR_W-1:0] word_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sp     <= SP_RESET;
      word_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (push_req) begin
            state  <= ST_PUSH_HI;
            word_q <= push_word;
          end else if (pop_req) begin
            state <= ST_POP_LO;
          end
        end
        ST_PUSH_HI: state <= ST_PUSH_LO;
        ST_PUSH_LO: begin
          state <= ST_IDLE;
          sp    <= sp - ADDR_W'(2);
        end
        ST_POP_LO: state <= ST_POP_HI;
        ST_POP_HI: begin
          state <= ST_POP_FIN;
          lo_q  <= mem_rdata;
        end
        ST_POP_FIN: begin
          state <= ST_IDLE;
          sp    <= sp + ADDR_W'(2);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_HI: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp - ADDR_W'(1);
        mem_wdata = word_q[ADDR_W-1:BYTE_W];
      end
      ST_PUSH_LO: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp - ADDR_W'(2);
        mem_wdata = word_q[BYTE_W-1:0];
      end
      ST_POP_LO: begin
        mem_en   = 1'b1;
        mem_addr = sp;
      end
      ST_POP_HI: begin
        mem_en   = 1'b1;
        mem_addr = sp + ADDR_W'(1);
      end
      default: ;
    endcase
  end

  assign idle     = (state == ST_IDLE);
  assign fin      = (state == ST_PUSH_LO) || (state == ST_POP_FIN);
  assign pop_word = {mem_rdata, lo_q};

  assert_push_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_HI) |=> (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(1)));
  assert_push_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_LO) |=> (sp == $past(sp) - ADDR_W'(2)));
  assert_pop_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POP_LO) |=> (mem_en && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));
  assert_pop_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POP_FIN) |=> (sp == $past(sp) + ADDR_W'(2)));
  assert_no_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !(push_req || pop_req));
  assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !push_req && !pop_req) |=> $stable(sp));
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_RESET = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [2:0]  op_kind,
  input  logic        op_cond_en,
  input  logic [2:0]  op_cond,
  input  logic [2:0]  op_vec,
  input  logic [7:0]  op_lo,
  input  logic [7:0]  op_hi,
  input  logic [15:0] hl,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic        flag_s,
  input  logic        flag_p,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        done,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  logic              pass, take, accept;
  logic              do_push, do_pop, push_req, pop_req;
  logic              stk_idle, stk_fin, pop_q;
  logic [ADDR_W-1:0] nxt, tgt, tgt_q, push_word, pop_word;
  logic [ADDR_W-1:0] seq1, seq3, imm, vec_tgt;

  flow_cond u_cond (
    .cond   (op_cond),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_s (flag_s),
    .flag_p (flag_p),
    .pass   (pass)
  );

  flow_stack #(.SP_RESET(SP_RESET)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_word (push_word),
    .idle      (stk_idle),
    .fin       (stk_fin),
    .pop_word  (pop_word),
    .sp        (sp),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign take    = !op_cond_en || pass;
  assign seq1    = pc + ADDR_W'(1);
  assign seq3    = pc + ADDR_W'(3);
  assign imm     = {op_hi, op_lo};
  assign vec_tgt = ADDR_W'(op_vec) << VEC_SHIFT;

  always_comb begin
    do_push   = 1'b0;
    do_pop    = 1'b0;
    nxt       = seq1;
    push_word = seq3;
    tgt       = imm;
    unique case (op_kind)
      K_JMP:  nxt = take ? imm : seq3;
      K_JHL:  nxt = hl;
      K_CALL: begin
        nxt     = seq3;
        do_push = take;
      end
      K_RET:  do_pop = take;
      K_RST: begin
        do_push   = 1'b1;
        push_word = seq1;
        tgt       = vec_tgt;
      end
      default: nxt = seq1;
    endcase
  end

  assign op_ready = stk_idle;
  assign accept   = op_valid && op_ready;
  assign push_req = accept && do_push;
  assign pop_req  = accept && do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= PC_RESET;
      done  <= 1'b0;
      tgt_q <= '0;
      pop_q <= 1'b0;
    end else begin
      if (accept) pop_q <= do_pop;
      if (push_req) tgt_q <= tgt;
      if (accept && !do_push && !do_pop) begin
        pc   <= nxt;
        done <= 1'b1;
      end else if (stk_fin) begin
        pc   <= pop_q ? pop_word : tgt_q;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end
  end

  assert_simple_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !do_push && !do_pop) |=> (done && op_ready));
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> !done);
  assert_stack_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |=> (!op_ready && $stable(pc)));
  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !stk_fin) |=> ($stable(pc) && !done));
endmodule

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
  localparam logic [15:0] PCR = 16'h0100;
  localparam logic [15:0] SPR = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = '0;
  logic        op_cond_en = 1'b0;
  logic [2:0]  op_cond = '0;
  logic [2:0]  op_vec = '0;
  logic [7:0]  op_lo = '0;
  logic [7:0]  op_hi = '0;
  logic [15:0] hl = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0, flag_s = 1'b0, flag_p = 1'b0;
  logic [15:0] pc, sp, mem_addr;
  logic        done, mem_en, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  rdq = '0;

  logic [7:0]  ram     [256];
  logic [7:0]  ref_mem [256];
  int unsigned acc_cnt = 0;
  int unsigned tick = 0;
  int          checks = 0;
  int          fails = 0;
  bit          ended = 1'b0;
  logic [15:0] m_pc, m_sp;

  always #5 clk = ~clk;

  flow_seq #(.PC_RESET(PCR), .SP_RESET(SPR)) u_flow_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_cond_en(op_cond_en), .op_cond(op_cond), .op_vec(op_vec),
    .op_lo(op_lo), .op_hi(op_hi), .hl(hl), .flag_z(flag_z), .flag_c(flag_c),
    .flag_s(flag_s), .flag_p(flag_p), .pc(pc), .sp(sp), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdq)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else        rdq <= ram[mem_addr[7:0]];
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick > 150000 && !ended) begin
      ended = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", tick);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [2:0] cd, input logic [3:0] f);
    // f = {z, c, s, p}
    case (cd)
      3'd0: return !f[3];
      3'd1: return f[3];
      3'd2: return !f[2];
      3'd3: return f[2];
      3'd4: return !f[0];
      3'd5: return f[0];
      3'd6: return !f[1];
      default: return f[1];
    endcase
  endfunction

  task automatic run_op(input logic [2:0] k, input logic ce, input logic [2:0] cd,
                        input logic [2:0] v, input logic [15:0] imm, input logic [15:0] hv,
                        input logic [3:0] f, input bit junk, input string req);
    logic [15:0] e_pc, e_sp, ret;
    int          e_cyc, e_acc, cyc;
    int unsigned acc0;
    bit          tk, rdy_bad, psh;
    tk    = !ce || cond_ok(cd, f);
    e_sp  = m_sp;
    e_cyc = 1;
    e_acc = 0;
    psh   = 1'b0;
    ret   = '0;
    case (k)
      3'd0: e_pc = tk ? imm : m_pc + 16'd3;
      3'd1: e_pc = hv;
      3'd2: begin
        e_pc = m_pc + 16'd3;
        if (tk) begin psh = 1'b1; ret = m_pc + 16'd3; e_pc = imm; end
      end
      3'd3: begin
        e_pc = m_pc + 16'd1;
        if (tk) begin
          e_pc  = {ref_mem[8'(m_sp + 16'd1)], ref_mem[m_sp[7:0]]};
          e_sp  = m_sp + 16'd2;
          e_cyc = 4;
          e_acc = 2;
        end
      end
      3'd4: begin psh = 1'b1; ret = m_pc + 16'd1; e_pc = {10'd0, v, 3'd0}; end
      default: e_pc = m_pc + 16'd1;
    endcase
    if (psh) begin
      ref_mem[8'(m_sp - 16'd1)] = ret[15:8];
      ref_mem[8'(m_sp - 16'd2)] = ret[7:0];
      e_sp  = m_sp - 16'd2;
      e_cyc = 3;
      e_acc = 2;
    end
    @(negedge clk);
    op_kind = k; op_cond_en = ce; op_cond = cd; op_vec = v;
    op_hi = imm[15:8]; op_lo = imm[7:0]; hl = hv;
    {flag_z, flag_c, flag_s, flag_p} = f;
    op_valid = 1'b1;
    acc0 = acc_cnt;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      op_kind = 3'd0; op_cond_en = 1'b0; op_hi = 8'hBE; op_lo = 8'hEF;
    end else begin
      op_valid = 1'b0;
    end
    cyc = 1;
    rdy_bad = 1'b0;
    while (!done && cyc < 10) begin
      if (op_ready) rdy_bad = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cyc = cyc + 1;
    end
    op_valid = 1'b0;
    chk(pc == e_pc, {req, " pc"}, 32'(pc), 32'(e_pc));
    chk(sp == e_sp, {req, " sp"}, 32'(sp), 32'(e_sp));
    chk(cyc == e_cyc, {req, " latency"}, 32'(cyc), 32'(e_cyc));
    chk((acc_cnt - acc0) == 32'(e_acc), {req, " accesses"}, 32'(acc_cnt - acc0), 32'(e_acc));
    chk(!rdy_bad, "R7 ready low while busy", 32'(rdy_bad), 32'd0);
    if (psh) begin
      chk(ram[8'(m_sp - 16'd1)] == ret[15:8], {req, " pushed high byte"},
          32'(ram[8'(m_sp - 16'd1)]), 32'(ret[15:8]));
      chk(ram[8'(m_sp - 16'd2)] == ret[7:0], {req, " pushed low byte"},
          32'(ram[8'(m_sp - 16'd2)]), 32'(ret[7:0]));
    end
    m_pc = e_pc;
    m_sp = e_sp;
  endtask

  initial begin
    logic [15:0] p0, s0;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; ref_mem[i] = 8'h00; end
    void'($urandom(32'd20240611));
    m_pc = PCR;
    m_sp = SPR;
    repeat (3) @(negedge clk);
    chk(!mem_en && !done, "R9 quiet in reset", {30'd0, mem_en, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == PCR, "R9 reset pc", 32'(pc), 32'(PCR));
    chk(sp == SPR, "R9 reset sp", 32'(sp), 32'(SPR));
    chk(op_ready && !done && !mem_en, "R9 reset handshake",
        {29'd0, op_ready, done, mem_en}, 32'd4);

    run_op(3'd0, 1'b0, 3'd0, 3'd0, 16'h2040, 16'h0, 4'h0, 1'b0, "R2 direct jump");
    for (int c = 0; c < 8; c++) begin
      run_op(3'd0, 1'b1, 3'(c), 3'd0, 16'h3000 + 16'(c), 16'h0, 4'h0, 1'b0, "R1 cond flags clear");
      run_op(3'd0, 1'b1, 3'(c), 3'd0, 16'h3100 + 16'(c), 16'h0, 4'hF, 1'b0, "R1 cond flags set");
    end
    run_op(3'd1, 1'b1, 3'd1, 3'd0, 16'h1111, 16'hA55A, 4'h0, 1'b0, "R3 HL jump");
    run_op(3'd2, 1'b0, 3'd0, 3'd0, 16'h4400, 16'h0, 4'h0, 1'b0, "R4 call");
    run_op(3'd2, 1'b1, 3'd3, 3'd0, 16'h5500, 16'h0, 4'h0, 1'b0, "R4 call not taken");
    run_op(3'd3, 1'b1, 3'd2, 3'd0, 16'h0, 16'h0, 4'h0, 1'b0, "R5 return");
    run_op(3'd3, 1'b1, 3'd1, 3'd0, 16'h0, 16'h0, 4'h0, 1'b0, "R5 return not taken");
    run_op(3'd4, 1'b1, 3'd1, 3'd5, 16'h9999, 16'h0, 4'h0, 1'b0, "R6 restart 5");
    run_op(3'd4, 1'b0, 3'd0, 3'd7, 16'h0, 16'h0, 4'h0, 1'b0, "R6 restart 7");
    run_op(3'd4, 1'b0, 3'd0, 3'd0, 16'h0, 16'h0, 4'h0, 1'b0, "R6 restart 0");
    run_op(3'd3, 1'b0, 3'd0, 3'd0, 16'h0, 16'h0, 4'h0, 1'b0, "R5 unwind");
    run_op(3'd2, 1'b0, 3'd0, 3'd0, 16'h6600, 16'h0, 4'h0, 1'b1, "R7 call with offer held");
    run_op(3'd3, 1'b0, 3'd0, 3'd0, 16'h0, 16'h0, 4'h0, 1'b1, "R7 return with offer held");
    for (int k = 5; k < 8; k++)
      run_op(3'(k), 1'b0, 3'd0, 3'd0, 16'h7777, 16'h8888, 4'h0, 1'b0, "R8 sequential kind");
    run_op(3'd0, 1'b0, 3'd0, 3'd0, 16'hFFFE, 16'h0, 4'h0, 1'b0, "R2 jump near top");
    run_op(3'd0, 1'b1, 3'd1, 3'd0, 16'h1234, 16'h0, 4'h0, 1'b0, "R2 wrap not taken");

    @(negedge clk);
    p0 = pc; s0 = sp;
    op_valid = 1'b0; op_kind = 3'd2; op_hi = 8'h12; hl = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk(pc == p0 && sp == s0 && !done, "R10 idle hold", {pc, sp}, {p0, s0});

    for (int n = 0; n < 400; n++) begin
      run_op(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
             3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
             4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), "R1 random mix");
    end

    if (!ended) begin
      ended = 1'b1;
      summary();
      $finish;
    end
  end
endmodule